// File: doc/BRIEF.md
# Peripheral Reset Generation Unit

This block is a register-mapped reset controller that drives 64 reset lines to on-chip peripherals and subsystems. Software uses a single-cycle register bus with address, write enable, write data and read data. Two control words set resets. Two status words report which lines are active, with a status bit reading 0 for an active line.

Most lines are pulse lines. A write of 1 starts a fixed-length pulse, and the line then releases itself. Two lines, numbers 12 and 56, are held lines. They stay asserted until software writes 0 to their bit. Because the status is active-low, software can write the inverted status back to a control word and keep its held lines asserted. Line 0 is the core reset. While it is active, every other line is forced active and a system-wide reset request is raised. When the core pulse ends, the held lines come back released.

Top module: `periph_reset_ctrl`

## Requirements
- R1: After power-up reset all 64 lines and the system request are low, both status words read 0xFFFFFFFF, and both control words read 0.
- R2: Line n belongs to word n/32, bit n%32. The control words sit at offsets 0x100 (lines 0-31) and 0x104 (lines 32-63) and read back the current line mask, with 1 meaning asserted. Read data reflects the addressed word in the same cycle.
- R3: The status words at 0x150 and 0x154 use the same bit mapping and read 0 for an active line and 1 for an inactive line. Writing the inverted status back to a control word keeps held lines asserted.
- R4: Writing 1 to the bit of a pulse line asserts it from the next cycle for exactly PULSE_LEN cycles (default 4). Writing 1 again while the pulse is running restarts the full count.
- R5: Writing 0 to the bit of a pulse line has no effect on that line.
- R6: Lines 12 (word 0x100 bit 12) and 56 (word 0x104 bit 24) are asserted by a write of 1. They stay asserted until a control write puts 0 in their bit, and they drop in the cycle after that write.
- R7: Line 0 is the core reset and is a pulse line. While it is active, all 64 lines and sys_reset_req are high.
- R8: When the core pulse ends, lines 12 and 56 are deasserted, even if they were held before it or written with 1 during it.
- R9: Any offset other than the four words reads 0. Writes to an unmapped offset or to a status word change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-up reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| rst_out | output | 64 | Reset lines, 1 means asserted |
| sys_reset_req | output | 1 | System-wide reset request, high while the core reset is active |

## Verification
The bench uses the default parameters: a 4-cycle pulse, held lines 12 and 56, and core line 0. With so short a pulse, random write traffic often lands on running pulses, so count restarts, writes of 0 to active pulse lines and overlapping core pulses all occur many times within a few hundred cycles. Directed sequences cover the exact pulse edges, the status write-back idiom and the release of held lines after a core pulse. Random writes to unmapped and status offsets check that such writes have no effect.

// File: rtl/rgu_pkg.sv
package rgu_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned CTRL_BASE = 32'h100;
    localparam int unsigned STAT_BASE = 32'h150;

    typedef enum logic {
        LINE_PULSE = 1'b0,
        LINE_HOLD  = 1'b1
    } line_kind_e;

endpackage

// File: rtl/rgu_reg_decode.sv
module rgu_reg_decode
    import rgu_pkg::*;
#(
    parameter int unsigned NUM_OUT = 64,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned NUM_WORDS = NUM_OUT / WORD_W
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [NUM_OUT-1:0]   line_mask_i,
    output logic [NUM_WORDS-1:0] wr_en_o,
    output logic [WORD_W-1:0]    rdata_o
);

    always_comb begin
        wr_en_o = '0;
        rdata_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr_i == ADDR_W'(CTRL_BASE + 4 * w)) begin
                wr_en_o[w] = we_i;
                rdata_o    = line_mask_i[w*WORD_W +: WORD_W];
            end
            if (addr_i == ADDR_W'(STAT_BASE + 4 * w)) begin
                rdata_o = ~line_mask_i[w*WORD_W +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/rgu_line.sv
module rgu_line
    import rgu_pkg::*;
#(
    parameter line_kind_e  KIND      = LINE_PULSE,
    parameter int unsigned PULSE_LEN = 4,
    localparam int unsigned CNT_W    = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic bit_i,
    input  logic force_clr_i,
    output logic active_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (KIND == LINE_HOLD) begin
            if (force_clr_i) begin
                st_d.hold = 1'b0;
            end else if (wr_i) begin
                st_d.hold = bit_i;
            end
        end else begin
            if (wr_i && bit_i) begin
                st_d.cnt = CNT_W'(PULSE_LEN);
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.cnt != '0) | st_q.hold;

endmodule

// File: rtl/periph_reset_ctrl.sv
module periph_reset_ctrl
    import rgu_pkg::*;
#(
    parameter int unsigned NUM_OUT   = 64,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned PULSE_LEN = 4,
    parameter int unsigned HOLD_A    = 12,
    parameter int unsigned HOLD_B    = 56,
    parameter int unsigned CORE_IDX  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic [NUM_OUT-1:0] rst_out,
    output logic               sys_reset_req
);

    localparam int unsigned NUM_WORDS = NUM_OUT / WORD_W;

    logic [NUM_WORDS-1:0] wr_en;
    logic [NUM_OUT-1:0]   line_act;
    logic                 core_active;

    assign core_active   = line_act[CORE_IDX];
    assign rst_out       = line_act | {NUM_OUT{core_active}};
    assign sys_reset_req = core_active;

    rgu_reg_decode #(
        .NUM_OUT (NUM_OUT),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr_i      (bus_addr),
        .we_i        (bus_we),
        .line_mask_i (rst_out),
        .wr_en_o     (wr_en),
        .rdata_o     (bus_rdata)
    );

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_line
        localparam line_kind_e K =
            (n == HOLD_A || n == HOLD_B) ? LINE_HOLD : LINE_PULSE;
        rgu_line #(
            .KIND      (K),
            .PULSE_LEN (PULSE_LEN)
        ) u_line (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (wr_en[n / WORD_W]),
            .bit_i       (bus_wdata[n % WORD_W]),
            .force_clr_i (core_active),
            .active_o    (line_act[n])
        );
    end

endmodule

// File: rtl/rgu_checker.sv
module rgu_checker #(
    parameter int unsigned NUM_OUT = 64,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned HOLD_A  = 12,
    parameter int unsigned HOLD_B  = 56
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_OUT-1:0] rst_out,
    input logic               sys_reset_req
);

    localparam logic [ADDR_W-1:0] A_C0 = ADDR_W'(32'h100);
    localparam logic [ADDR_W-1:0] A_C1 = ADDR_W'(32'h104);
    localparam logic [ADDR_W-1:0] A_S0 = ADDR_W'(32'h150);
    localparam logic [ADDR_W-1:0] A_S1 = ADDR_W'(32'h154);

    logic mapped;
    assign mapped = (bus_addr == A_C0) || (bus_addr == A_C1) ||
                    (bus_addr == A_S0) || (bus_addr == A_S1);

    a_r7_core_forces_all: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out[0] |-> (&rst_out));

    a_r7_sys_request: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req == rst_out[0]);

    a_r3_status_low_active: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_S0) |-> (bus_rdata == ~rst_out[31:0]));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));

    a_r4_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_C0 && bus_wdata[5]) |=> rst_out[5]);

    a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_out[HOLD_A] && !rst_out[0] &&
         !(bus_we && bus_addr == A_C0 && !bus_wdata[HOLD_A % 32])) |=> rst_out[HOLD_A]);

    a_r8_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out[0]) |-> (!rst_out[HOLD_A] && !rst_out[HOLD_B]));

endmodule

bind periph_reset_ctrl rgu_checker #(
    .NUM_OUT (NUM_OUT),
    .ADDR_W  (ADDR_W),
    .HOLD_A  (HOLD_A),
    .HOLD_B  (HOLD_B)
) u_rgu_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .rst_out       (rst_out),
    .sys_reset_req (sys_reset_req)
);

// File: tb/test_periph_reset_ctrl.sv
`timescale 1ns/100ps
module test_periph_reset_ctrl;

    localparam int L = 4;
    localparam logic [11:0] C0 = 12'h100, C1 = 12'h104, S0 = 12'h150, S1 = 12'h154;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] rst_out;
    logic        sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int exp_cnt [64];
    bit exp_hold [64];

    always #2.5 clk = ~clk;

    periph_reset_ctrl i_periph_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_out(rst_out),
        .sys_reset_req(sys_reset_req)
    );

    function automatic bit is_hold(int n);
        return (n == 12) || (n == 56);
    endfunction

    function automatic logic [63:0] exp_mask();
        logic [63:0] m;
        bit core = (exp_cnt[0] != 0);
        for (int n = 0; n < 64; n++) m[n] = core || exp_cnt[n] != 0 || exp_hold[n];
        return m;
    endfunction

    function automatic void model_step(logic we, logic [11:0] a, logic [31:0] d);
        bit core = (exp_cnt[0] != 0);
        for (int n = 0; n < 64; n++) begin
            bit wr = we && (a == ((n < 32) ? C0 : C1));
            bit b  = d[n % 32];
            if (is_hold(n)) begin
                if (core) exp_hold[n] = 0;
                else if (wr) exp_hold[n] = b;
            end else begin
                if (wr && b) exp_cnt[n] = L;
                else if (exp_cnt[n] > 0) exp_cnt[n]--;
            end
        end
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic we, input logic [11:0] a, input logic [31:0] d);
        bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.2;
        chk(req, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic check_all(input string req);
        logic [63:0] m = exp_mask();
        chk(req, rst_out, m);
        chk("R7 sys_reset_req", {63'h0, sys_reset_req}, {63'h0, m[0]});
        read_chk("R2 ctrl0 readback", C0, m[31:0]);
        read_chk("R2 ctrl1 readback", C1, m[63:32]);
        read_chk("R3 status0", S0, ~m[31:0]);
        read_chk("R3 status1", S1, ~m[63:32]);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] st;
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 64; n++) begin exp_cnt[n] = 0; exp_hold[n] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 lines after reset", rst_out, 64'h0);
        read_chk("R1 status0 reset", S0, 32'hFFFF_FFFF);
        read_chk("R1 status1 reset", S1, 32'hFFFF_FFFF);
        read_chk("R1 ctrl0 reset", C0, 32'h0);

        // R4 exact pulse length on line 5
        tick(1, C0, 32'h20);
        for (int i = 0; i < L; i++) begin
            chk("R4 pulse high", {63'h0, rst_out[5]}, 64'h1);
            tick(0, C0, 0);
        end
        chk("R4 pulse released", {63'h0, rst_out[5]}, 64'h0);

        // R4 restart and R5 zero-write ignored
        tick(1, C0, 32'h20);
        tick(1, C0, 32'h0);
        chk("R5 zero write keeps pulse", {63'h0, rst_out[5]}, 64'h1);
        tick(1, C0, 32'h20);
        for (int i = 0; i < L; i++) begin
            check_all("R4 restart window");
            tick(0, C0, 0);
        end
        chk("R4 restarted pulse ends", {63'h0, rst_out[5]}, 64'h0);

        // R6 held lines, line 40 pulse in word 1
        tick(1, C0, 32'h1000);
        tick(1, C1, 32'h0100_0100);
        repeat (8) tick(0, C0, 0);
        check_all("R6 held lines stay");
        chk("R6 line 12 held", {63'h0, rst_out[12]}, 64'h1);
        chk("R6 line 56 held", {63'h0, rst_out[56]}, 64'h1);

        // R3 write back inverted status keeps held line
        bus_addr = S0; #0.2; st = bus_rdata;
        tick(1, C0, ~st);
        check_all("R3 write-back keeps hold");
        chk("R3 line 12 after write-back", {63'h0, rst_out[12]}, 64'h1);
        tick(1, C0, 32'h0);
        chk("R6 line 12 released", {63'h0, rst_out[12]}, 64'h0);
        tick(1, C0, 32'h1000);

        // R7 core pulse forces all, R8 holds cleared afterwards
        tick(1, C0, 32'h1);
        for (int i = 0; i < L; i++) begin
            chk("R7 all forced", rst_out, 64'hFFFF_FFFF_FFFF_FFFF);
            check_all("R7 core window");
            tick(1, C1, 32'h0100_0000);
        end
        check_all("R8 after core");
        chk("R8 held lines cleared", {62'h0, rst_out[56], rst_out[12]}, 64'h0);

        // R9 unmapped and status writes ignored
        repeat (L) tick(0, C0, 0);
        tick(1, 12'h108, 32'hFFFF_FFFF);
        tick(1, S0, 32'hFFFF_FFFF);
        tick(1, 12'h000, 32'hFFFF_FFFF);
        chk("R9 writes ignored", rst_out, 64'h0);
        read_chk("R9 unmapped read 0x108", 12'h108, 32'h0);
        read_chk("R9 unmapped read 0x000", 12'h000, 32'h0);

        // Random traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            logic [31:0] d = $urandom;
            case ($urandom % 6)
                0, 1: a = C0;
                2:    a = C1;
                3:    a = S0;
                4:    a = 12'h108;
                default: a = S1;
            endcase
            if (a == C0 && ($urandom % 16) != 0) d[0] = 1'b0;
            tick(($urandom % 3) != 0, a, d);
            check_all("R4 R5 R6 random");
            read_chk("R9 random unmapped", 12'h1FC, 32'h0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule